// File: doc/BRIEF.md
# DMA Channel Transfer Engine

This block is one DMA channel that moves data between a peripheral and memory on demand. Software loads a start address, a transfer count and a mode through a small register write port. A DMA cycle is a single transfer of one data item. While the peripheral holds its request high and the channel is unmasked, the engine runs one DMA cycle after another. For each one it drives the acknowledge, puts the current address on the address output and asserts the pair of strobes that suits the transfer type. After each completed cycle it steps the address and counts the word count down.

When the request drops, service pauses. The current address and count keep their values, and service picks up from them when the request comes back. Service ends in one of two ways: the count passes below zero (terminal count), or an external end-of-process input arrives while the channel is serving. The engine then raises a one-cycle end-of-process output. After that it either masks itself or, if auto-reload is selected, copies the base registers back into the current registers. With auto-reload the channel is at once ready for the next request.

The controller is built around four named states:
- `ST_IDLE` waits for an unmasked request.
- `ST_XFER` is the first cycle of a DMA cycle.
- `ST_WAIT` holds a DMA cycle while the ready input is low.
- `ST_TERM` is the single end-of-process cycle.

The transitions are:
- **start**: `ST_IDLE` to `ST_XFER`.
- **next**: `ST_XFER` or `ST_WAIT` back to `ST_XFER` when the request is still high.
- **pause**: back to `ST_IDLE` when the request is low.
- **stall**: `ST_XFER` to `ST_WAIT`, and staying in `ST_WAIT` while ready is low.
- **finish**: to `ST_TERM`, on terminal count or on the external end-of-process input.
- **rearm**: `ST_TERM` to `ST_IDLE`.

Top module: `dma_chan_engine`

## Requirements
- R1: A register write with `reg_sel`=0 loads both the base and current address, and `reg_sel`=1 loads both the base and current count (the low count bits of `reg_wdata`). With `reg_sel`=2, the mode register takes these fields: bits [1:0] are the transfer type (01 write, 10 read, 00 or 11 verify), bit 4 enables auto-reload and bit 5 selects decrement. With `reg_sel`=3, bit 0 becomes the mask. Reset sets the mask and clears every other register. While masked, the channel ignores `dreq`.
- R2: In `ST_IDLE`, with `dreq` high and the mask clear, `dack` is high one cycle later and `addr_out` shows the current address. Each completed DMA cycle steps the address by one and decrements the count.
- R3: If `dreq` is low when a DMA cycle completes, `dack` falls on the next cycle and the current address and count hold their values. When `dreq` returns, service resumes from those values.
- R4: A write transfer asserts `mem_wr` and `io_rd` together. A read transfer asserts `mem_rd` and `io_wr` together. No strobe is active while `dack` is low.
- R5: A verify transfer keeps all four strobes low and ignores `ready`, so it completes one DMA cycle per clock.
- R6: In a non-verify transfer, `ready` low holds the DMA cycle: `dack`, the strobes and `addr_out` stay unchanged and nothing is counted until a cycle in which `ready` is high.
- R7: A DMA cycle that completes with a count of zero wraps the count to all ones (terminal count). One cycle later, `eop_out` is high for exactly one cycle with `dack` low.
- R8: `eop_in` high during `ST_XFER` or `ST_WAIT` ends service at the next edge without counting the DMA cycle in progress, and `eop_out` pulses. Outside service, `eop_in` has no effect.
- R9: At the end of service without auto-reload, the mask is set and the current registers keep their final values. With auto-reload, the mask stays clear and the current registers are restored from the base registers, so a held `dreq` restarts service from the base address with no register write.
- R10: `stat_tc` is set by terminal count but not by `eop_in`, and is cleared by a `stat_rd` pulse. A set in the same cycle wins over the clear.
- R11: With the decrement bit clear the address counts up by one per DMA cycle. With it set, the address counts down by one, modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 count, 2 mode, 3 mask |
| reg_wdata | input | ADDR_W | Register write data |
| stat_rd | input | 1 | Status read; clears the terminal-count flag |
| dreq | input | 1 | Peripheral service request |
| ready | input | 1 | Memory/peripheral ready; low inserts wait cycles |
| eop_in | input | 1 | External end-of-process request |
| dack | output | 1 | Service acknowledge, high during DMA cycles |
| addr_out | output | ADDR_W | Current transfer address, zero outside service |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Peripheral read strobe |
| io_wr | output | 1 | Peripheral write strobe |
| eop_out | output | 1 | One-cycle end-of-process indication |
| chan_mask | output | 1 | Channel mask state |
| stat_tc | output | 1 | Terminal-count status flag |

## Verification
Every output is decoded from the state and current registers, so a result is due exactly one edge after the inputs that cause it. `dack` and the first address appear one edge after `dreq` is seen in `ST_IDLE`. Each following address appears one edge after the DMA cycle completes. `eop_out` appears one edge after the last DMA cycle. The mask, or the restored registers, take effect one edge after `eop_out`. The bench changes inputs and samples outputs one nanosecond after each rising edge, and it counts edges from each stimulus to read every result in the cycle it is due. That includes the extra cycles that a low `ready` inserts.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [1:0] {
        XT_VERIFY  = 2'b00,
        XT_WRITE   = 2'b01,
        XT_READ    = 2'b10,
        XT_VERIFY2 = 2'b11
    } xfer_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_WAIT,
        ST_TERM
    } chan_state_e;

    typedef enum logic [1:0] {
        RS_ADDR  = 2'd0,
        RS_COUNT = 2'd1,
        RS_MODE  = 2'd2,
        RS_MASK  = 2'd3
    } reg_sel_e;

    localparam int MODE_AUTO_BIT = 4;
    localparam int MODE_DEC_BIT  = 5;

    typedef struct packed {
        logic       dec;
        logic       auto_init;
        xfer_kind_e kind;
    } mode_t;

    function automatic logic is_verify(input xfer_kind_e k);
        return (k == XT_VERIFY) || (k == XT_VERIFY2);
    endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    input  logic              stat_rd,
    input  logic              step,
    input  logic              term,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_cnt,
    output logic              cnt_zero,
    output mode_t             mode_q,
    output logic              mask_q,
    output logic              tc_q
);

    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

    logic [ADDR_W-1:0] base_addr;
    logic [CNT_W-1:0]  base_cnt;
    logic              tc_hit;

    assign cnt_zero = (cur_cnt == '0);
    assign tc_hit   = step && cnt_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_addr <= '0;
            base_cnt  <= '0;
            cur_addr  <= '0;
            cur_cnt   <= '0;
            mode_q    <= '0;
            mask_q    <= 1'b1;
        end else begin
            if (step) begin
                cur_addr <= mode_q.dec ? cur_addr - ADDR_ONE : cur_addr + ADDR_ONE;
                cur_cnt  <= cur_cnt - CNT_ONE;
            end
            if (term) begin
                if (mode_q.auto_init) begin
                    cur_addr <= base_addr;
                    cur_cnt  <= base_cnt;
                end else begin
                    mask_q <= 1'b1;
                end
            end
            if (reg_wr) begin
                unique case (reg_sel_e'(reg_sel))
                    RS_ADDR: begin
                        base_addr <= reg_wdata;
                        cur_addr  <= reg_wdata;
                    end
                    RS_COUNT: begin
                        base_cnt <= reg_wdata[CNT_W-1:0];
                        cur_cnt  <= reg_wdata[CNT_W-1:0];
                    end
                    RS_MODE: begin
                        mode_q.kind      <= xfer_kind_e'(reg_wdata[1:0]);
                        mode_q.auto_init <= reg_wdata[MODE_AUTO_BIT];
                        mode_q.dec       <= reg_wdata[MODE_DEC_BIT];
                    end
                    RS_MASK: mask_q <= reg_wdata[0];
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tc_q <= 1'b0;
        end else if (tc_hit) begin
            tc_q <= 1'b1;
        end else if (stat_rd) begin
            tc_q <= 1'b0;
        end
    end

endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
    import dma_chan_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dreq,
    input  logic        ready,
    input  logic        eop_in,
    input  logic        mask_q,
    input  logic        cnt_zero,
    input  xfer_kind_e  kind,
    output chan_state_e state_q,
    output logic        step,
    output logic        term
);

    chan_state_e state_d;
    logic        cycle_ok;
    chan_state_e after_done;

    assign cycle_ok   = ready || is_verify(kind);
    assign after_done = cnt_zero ? ST_TERM : (dreq ? ST_XFER : ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        step    = 1'b0;
        term    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (dreq && !mask_q) begin
                    state_d = ST_XFER;
                end
            end
            ST_XFER, ST_WAIT: begin
                if (eop_in) begin
                    state_d = ST_TERM;
                end else if (cycle_ok) begin
                    step    = 1'b1;
                    state_d = after_done;
                end else begin
                    state_d = ST_WAIT;
                end
            end
            ST_TERM: begin
                term    = 1'b1;
                state_d = ST_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/dma_chan_outdec.sv
module dma_chan_outdec
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  chan_state_e       state_q,
    input  xfer_kind_e        kind,
    input  logic [ADDR_W-1:0] cur_addr,
    output logic              dack,
    output logic [ADDR_W-1:0] addr_out,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              io_rd,
    output logic              io_wr,
    output logic              eop_out
);

    always_comb begin
        dack     = 1'b0;
        addr_out = '0;
        mem_rd   = 1'b0;
        mem_wr   = 1'b0;
        io_rd    = 1'b0;
        io_wr    = 1'b0;
        eop_out  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_XFER, ST_WAIT: begin
                dack     = 1'b1;
                addr_out = cur_addr;
                if (kind == XT_WRITE) begin
                    mem_wr = 1'b1;
                    io_rd  = 1'b1;
                end else if (kind == XT_READ) begin
                    mem_rd = 1'b1;
                    io_wr  = 1'b1;
                end
            end
            ST_TERM: eop_out = 1'b1;
        endcase
    end

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    input  logic              stat_rd,
    input  logic              dreq,
    input  logic              ready,
    input  logic              eop_in,
    output logic              dack,
    output logic [ADDR_W-1:0] addr_out,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              io_rd,
    output logic              io_wr,
    output logic              eop_out,
    output logic              chan_mask,
    output logic              stat_tc
);

    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  cur_cnt;
    logic              cnt_zero;
    mode_t             mode_q;
    chan_state_e       state_q;
    logic              step;
    logic              term;
    logic              auto_en;

    assign auto_en = mode_q.auto_init;

    dma_chan_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .stat_rd   (stat_rd),
        .step      (step),
        .term      (term),
        .cur_addr  (cur_addr),
        .cur_cnt   (cur_cnt),
        .cnt_zero  (cnt_zero),
        .mode_q    (mode_q),
        .mask_q    (chan_mask),
        .tc_q      (stat_tc)
    );

    dma_chan_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .dreq     (dreq),
        .ready    (ready),
        .eop_in   (eop_in),
        .mask_q   (chan_mask),
        .cnt_zero (cnt_zero),
        .kind     (mode_q.kind),
        .state_q  (state_q),
        .step     (step),
        .term     (term)
    );

    dma_chan_outdec #(.ADDR_W(ADDR_W)) u_out (
        .state_q  (state_q),
        .kind     (mode_q.kind),
        .cur_addr (cur_addr),
        .dack     (dack),
        .addr_out (addr_out),
        .mem_rd   (mem_rd),
        .mem_wr   (mem_wr),
        .io_rd    (io_rd),
        .io_wr    (io_wr),
        .eop_out  (eop_out)
    );

endmodule

// File: rtl/dma_chan_checks.sv
module dma_chan_checks #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              stat_rd,
    input logic              ready,
    input logic              eop_in,
    input logic              dack,
    input logic [ADDR_W-1:0] addr_out,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              io_rd,
    input logic              io_wr,
    input logic              eop_out,
    input logic              chan_mask,
    input logic              stat_tc,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [CNT_W-1:0]  cur_cnt,
    input logic              auto_en
);

    a_r4_write_pair: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (io_rd && !mem_rd && !io_wr));

    a_r4_read_pair: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (io_wr && !mem_wr && !io_rd));

    a_r4_strobe_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr || io_rd || io_wr) |-> dack);

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!dack && !eop_out && !reg_wr) |=> ($stable(cur_addr) && $stable(cur_cnt)));

    a_r6_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dack && !ready && (mem_rd || mem_wr) && !eop_in && !reg_wr)
            |=> (dack && $stable(addr_out)));

    a_r7_eop_single: assert property (@(posedge clk) disable iff (!rst_n)
        eop_out |=> (!eop_out && !dack));

    a_r8_eop_needs_service: assert property (@(posedge clk) disable iff (!rst_n)
        (!dack && !eop_out) |=> !eop_out);

    a_r9_mask_on_end: assert property (@(posedge clk) disable iff (!rst_n)
        (eop_out && !auto_en && !reg_wr) |=> chan_mask);

    a_r9_auto_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (eop_out && auto_en && !reg_wr) |=> $stable(chan_mask));

    a_r10_tc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_tc && !stat_rd) |=> stat_tc);

endmodule

bind dma_chan_engine dma_chan_checks #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .stat_rd   (stat_rd),
    .ready     (ready),
    .eop_in    (eop_in),
    .dack      (dack),
    .addr_out  (addr_out),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .io_rd     (io_rd),
    .io_wr     (io_wr),
    .eop_out   (eop_out),
    .chan_mask (chan_mask),
    .stat_tc   (stat_tc),
    .cur_addr  (cur_addr),
    .cur_cnt   (cur_cnt),
    .auto_en   (auto_en)
);

// File: tb/test_dma_chan_engine.sv
module test_dma_chan_engine;

    localparam int AW = 8;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_sel = '0;
    logic [AW-1:0] reg_wdata = '0;
    logic          stat_rd = 1'b0;
    logic          dreq = 1'b0;
    logic          ready = 1'b1;
    logic          eop_in = 1'b0;
    logic          dack, mem_rd, mem_wr, io_rd, io_wr, eop_out, chan_mask, stat_tc;
    logic [AW-1:0] addr_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dma_chan_engine #(.ADDR_W(AW), .CNT_W(CW)) i_dma_chan_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .stat_rd(stat_rd), .dreq(dreq), .ready(ready),
        .eop_in(eop_in), .dack(dack), .addr_out(addr_out), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr), .eop_out(eop_out),
        .chan_mask(chan_mask), .stat_tc(stat_tc)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int sel, input int data);
        reg_wr    = 1'b1;
        reg_sel   = 2'(sel);
        reg_wdata = AW'(data);
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic clear_status();
        stat_rd = 1'b1;
        tick();
        stat_rd = 1'b0;
    endtask

    function automatic int step_addr(input int a, input int n, input int dec);
        return dec ? ((a - n) & 8'hFF) : ((a + n) & 8'hFF);
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        tick();
        tick();
        rst_n = 1'b1;
        tick();
        // R1: reset state and masked channel ignores request
        chk("R1 reset mask", chan_mask, 1);
        chk("R1 reset dack", dack, 0);
        chk("R10 reset tc", stat_tc, 0);
        dreq = 1'b1;
        tick();
        tick();
        chk("R1 masked ignores dreq", dack, 0);
        dreq = 1'b0;

        // Sweep: type x direction x count, request held for the whole service
        for (int k = 0; k < 3; k++) begin
            for (int dir = 0; dir < 2; dir++) begin
                for (int c = 0; c < 4; c++) begin
                    int a = 100 + 7 * k + c;
                    int kind = (k == 0) ? 1 : ((k == 1) ? 2 : 0);
                    wr(0, a);
                    wr(1, c);
                    wr(2, (dir << 5) | kind);
                    wr(3, 0);
                    clear_status();
                    ready = (kind == 0) ? 1'b0 : 1'b1; // R5: verify ignores ready
                    dreq = 1'b1;
                    for (int t = 0; t <= c; t++) begin
                        tick();
                        chk("R2 dack", dack, 1);
                        chk("R11 addr", addr_out, step_addr(a, t, dir));
                        chk("R4 mem_wr", mem_wr, kind == 1);
                        chk("R4 io_rd", io_rd, kind == 1);
                        chk("R4 mem_rd", mem_rd, kind == 2);
                        chk("R5 io_wr", io_wr, kind == 2);
                    end
                    tick();
                    chk("R7 eop_out", eop_out, 1);
                    chk("R7 dack low", dack, 0);
                    dreq = 1'b0;
                    tick();
                    chk("R7 eop one cycle", eop_out, 0);
                    chk("R9 mask set", chan_mask, 1);
                    chk("R10 tc set", stat_tc, 1);
                    wr(3, 0);
                    dreq = 1'b1;
                    tick();
                    chk("R9 final addr kept", addr_out, step_addr(a, c + 1, dir));
                    dreq = 1'b0;
                    tick();
                    ready = 1'b1;
                    tick();
                end
            end
        end

        // R10: status clear by read
        clear_status();
        chk("R10 tc cleared", stat_tc, 0);

        // R3: pause and resume
        wr(0, 20);
        wr(1, 5);
        wr(2, 1);
        wr(3, 0);
        dreq = 1'b1;
        tick();
        chk("R3 first addr", addr_out, 20);
        dreq = 1'b0;
        tick();
        chk("R3 paused", dack, 0);
        tick();
        tick();
        chk("R3 still paused", dack, 0);
        dreq = 1'b1;
        for (int t = 1; t <= 5; t++) begin
            tick();
            chk("R3 resumed addr", addr_out, 20 + t);
            if (t == 2) begin
                dreq = 1'b0;
                tick();
                chk("R3 second pause", dack, 0);
                dreq = 1'b1;
            end
        end
        tick();
        chk("R3 tc after resumed count", eop_out, 1);
        dreq = 1'b0;
        tick();

        // R6: ready wait states on a read transfer
        wr(0, 50);
        wr(1, 1);
        wr(2, 2);
        wr(3, 0);
        ready = 1'b0;
        dreq = 1'b1;
        tick();
        chk("R6 start addr", addr_out, 50);
        tick();
        chk("R6 wait dack", dack, 1);
        chk("R6 wait addr", addr_out, 50);
        chk("R6 wait strobe", mem_rd, 1);
        tick();
        chk("R6 wait addr 2", addr_out, 50);
        ready = 1'b1;
        tick();
        chk("R6 advanced", addr_out, 51);
        tick();
        chk("R6 eop", eop_out, 1);
        dreq = 1'b0;
        tick();

        // R8: external end of process
        wr(0, 70);
        wr(1, 9);
        wr(2, 1);
        wr(3, 0);
        clear_status();
        eop_in = 1'b1;
        tick();
        tick();
        chk("R8 idle eop no pulse", eop_out, 0);
        chk("R8 idle eop no mask", chan_mask, 0);
        eop_in = 1'b0;
        dreq = 1'b1;
        tick();
        chk("R8 addr 70", addr_out, 70);
        tick();
        chk("R8 addr 71", addr_out, 71);
        eop_in = 1'b1;
        tick();
        chk("R8 eop_out", eop_out, 1);
        chk("R8 dack low", dack, 0);
        eop_in = 1'b0;
        dreq = 1'b0;
        tick();
        chk("R8 mask set", chan_mask, 1);
        chk("R10 no tc on external eop", stat_tc, 0);
        wr(3, 0);
        dreq = 1'b1;
        tick();
        chk("R8 cycle not counted", addr_out, 71);
        dreq = 1'b0;
        tick();
        tick();

        // R9: auto-reload with verify, request held
        wr(0, 90);
        wr(1, 1);
        wr(2, 32'h10);
        wr(3, 0);
        clear_status();
        dreq = 1'b1;
        tick();
        chk("R9 addr 90", addr_out, 90);
        tick();
        chk("R9 addr 91", addr_out, 91);
        tick();
        chk("R9 eop", eop_out, 1);
        tick();
        chk("R9 mask stays clear", chan_mask, 0);
        chk("R10 tc on auto", stat_tc, 1);
        tick();
        chk("R9 restart base", addr_out, 90);
        tick();
        chk("R9 restart next", addr_out, 91);
        dreq = 1'b0;
        tick();
        chk("R9 second eop", eop_out, 1);
        tick();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule